// File: doc/BRIEF.md
# Full-Duplex Serial Shift Engine

This block is the bit-level engine of a serial peripheral master. A one-cycle start request launches a single full-duplex exchange of between 1 and 64 bits. The engine divides the system clock down to a serial clock, drives outgoing bits on MOSI, samples MISO, and reports progress through a busy level and a one-cycle done pulse. Register decoding and slave-select control belong to the surrounding logic and are not part of this block.

Each transfer has three independent settings. The launch edge can be the falling edge (the usual choice) or the rising edge of the serial clock. The sample edge can be the rising edge (the usual choice) or the falling edge. The bit order can be MSB first or LSB first. All settings, including the character length and the clock divider, are captured when the transfer starts.

One register serves both directions. Each bit received from MISO replaces a bit that has already been shifted out. When the transfer ends, the low character-length bits of the register hold the received word, so a second transfer with no reload in between sends that word back out.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, sclk, mosi, busy and done are 0 and data_out is all zeros.
- R2: The serial clock idles low. After an accepted start it makes its first edge divider+1 system cycles later. It then toggles every divider+1 cycles and stops low after exactly 2·N edges, where N is the transfer length.
- R3: char_len sets N. A char_len of 0 gives N = 64 (DATA_W).
- R4: With launch_rise = 0, the first outgoing bit appears on mosi in the cycle after the start is accepted, and each later bit appears after a falling edge. With launch_rise = 1, mosi changes only after rising edges, and bit k appears after rising edge k. At all other times mosi holds its value.
- R5: With sample_fall = 0, MISO is captured on rising edges. With sample_fall = 1, it is captured on falling edges. The sample edge is chosen independently of the launch edge.
- R6: With lsb_first = 0, bits go out from bit N-1 down to bit 0. With lsb_first = 1, they go out from bit 0 up to bit N-1.
- R7: After the transfer, data_out[N-1:0] holds the received bits. With lsb_first = 0 the first received bit sits at bit N-1; with lsb_first = 1 it sits at bit 0. Bits above N-1 are unchanged. A following transfer with no load sends these received bits.
- R8: busy rises in the cycle after an accepted start and falls together with the final serial clock edge. done is high for exactly one cycle, the cycle in which busy has just fallen.
- R9: While busy is high, start, load and every configuration input (char_len, divider, launch_rise, sample_fall, lsb_first) have no effect on the transfer in progress.
- R10: When busy is low, load writes load_data into data_out on the next cycle. A start in the same cycle as a load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle transfer request |
| char_len | input | IDX_W (6) | Transfer length, 0 means DATA_W |
| divider | input | DIV_W (16) | Serial clock half period minus one, in system cycles |
| launch_rise | input | 1 | 1: launch on rising edges, 0: on falling edges |
| sample_fall | input | 1 | 1: sample on falling edges, 0: on rising edges |
| lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| load | input | 1 | Write load_data into the shared register |
| load_data | input | DATA_W (64) | Value for the shared register |
| miso | input | 1 | Serial input data |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial output data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| data_out | output | DATA_W (64) | Shared transmit/receive register |

## Verification
A wrong edge counter or divider count shows up on sclk within one half-period, and the final edge or the busy/done timing is then off by whole half-periods. A wrong head-bit selection or launch decision shows up on mosi at the first launch edge of the affected setting. A fault in the shift path shows up on data_out at the very next sample edge, because the register is visible on the ports every cycle. A reference model in the bench predicts all five outputs on every clock, so any of these faults is caught in the cycle it first appears.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  // transfer mode captured at start
  typedef struct packed {
    logic launch_rise;  // 1: drive mosi after rising edges
    logic sample_fall;  // 1: capture miso on falling edges
    logic lsb_first;    // 1: bit 0 leaves first
  } spi_mode_t;

endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             tick,
  output logic             sclk
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == divider);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == divider) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk <= 1'b0;
    end else if (tick) begin
      sclk <= ~sclk;
    end else if (!run) begin
      sclk <= 1'b0;
    end
  end

  // R2: no serial clock activity outside a transfer
  p_sclk_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !run |-> !sclk);

endmodule

// File: rtl/spi_shift_reg.sv
module spi_shift_reg #(
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  input  logic              miso,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              lsb_first,
  input  logic              launch_en,
  input  logic              launch_next,
  output logic              mosi,
  output logic [DATA_W-1:0] sr_q
);

  logic [DATA_W-1:0] sr_nxt;
  logic              head_cur;
  logic              head_nxt;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic in_rng;
    logic up_src;
    logic dn_src;
    assign in_rng = (IDX_W'(i) <= last_idx);
    if (i == 0) begin : g_lo
      assign up_src = miso;
    end else begin : g_lo_n
      assign up_src = sr_q[i-1];
    end
    if (i == DATA_W-1) begin : g_hi
      assign dn_src = sr_q[i];
    end else begin : g_hi_n
      assign dn_src = sr_q[i+1];
    end
    assign sr_nxt[i] = !in_rng ? sr_q[i] :
                       (lsb_first ? ((IDX_W'(i) == last_idx) ? miso : dn_src) : up_src);
  end

  assign head_cur = lsb_first ? sr_q[0]   : sr_q[last_idx];
  assign head_nxt = lsb_first ? sr_nxt[0] : sr_nxt[last_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
      mosi <= 1'b0;
    end else begin
      if (load_i) begin
        sr_q <= load_data;
      end else if (shift_en) begin
        sr_q <= sr_nxt;
      end
      if (launch_en) begin
        mosi <= launch_next ? head_nxt : head_cur;
      end
    end
  end

  // R10: register only changes through load or an active transfer
  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy_i && !load_i) |=> $stable(sr_q));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DIV_W  = 16,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int EDG_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  char_len,
  input  logic [DIV_W-1:0]  divider,
  input  logic              launch_rise,
  input  logic              sample_fall,
  input  logic              lsb_first,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] data_out
);

  spi_mode_t        mode_in, mode_q, mode_use;
  logic [IDX_W-1:0] last_in, last_q, last_use;
  logic [DIV_W-1:0] div_q;
  logic [EDG_W-1:0] edge_q;
  logic             busy_q, done_q;
  logic             start_ok, load_ok, tick, last_edge;
  logic             sample_now, launch_tick, launch_en, launch_next;

  // char_len 0 wraps to DATA_W-1 (DATA_W is a power of two)
  assign last_in  = char_len - 1'b1;
  assign mode_in  = '{launch_rise: launch_rise, sample_fall: sample_fall, lsb_first: lsb_first};
  assign mode_use = busy_q ? mode_q : mode_in;
  assign last_use = busy_q ? last_q : last_in;

  assign load_ok  = load & ~busy_q;
  assign start_ok = start & ~busy_q & ~load;

  // edge_q even: rising edge next, odd: falling edge next
  assign last_edge   = (edge_q == {last_q, 1'b1});
  assign sample_now  = tick & (edge_q[0] == mode_q.sample_fall);
  assign launch_tick = tick & (mode_q.launch_rise ? ~edge_q[0] : (edge_q[0] & ~last_edge));
  assign launch_en   = launch_tick | (start_ok & ~mode_in.launch_rise);
  assign launch_next = sample_now & ~mode_q.launch_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      edge_q <= '0;
      mode_q <= '0;
      last_q <= '0;
      div_q  <= '0;
    end else begin
      done_q <= tick & last_edge;
      if (start_ok) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        mode_q <= mode_in;
        last_q <= last_in;
        div_q  <= divider;
      end else if (tick) begin
        edge_q <= edge_q + 1'b1;
        if (last_edge) begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  spi_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (busy_q),
    .divider (div_q),
    .tick    (tick),
    .sclk    (sclk)
  );

  spi_shift_reg #(.DATA_W(DATA_W)) u_sr (
    .clk         (clk),
    .rst         (rst),
    .busy_i      (busy_q),
    .load_i      (load_ok),
    .load_data   (load_data),
    .shift_en    (sample_now),
    .miso        (miso),
    .last_idx    (last_use),
    .lsb_first   (mode_use.lsb_first),
    .launch_en   (launch_en),
    .launch_next (launch_next),
    .mosi        (mosi),
    .sr_q        (data_out)
  );

  assign busy = busy_q;
  assign done = done_q;

  // R8: done lasts a single cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: done marks the cycle right after busy drops
  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R9: captured settings stay frozen during a transfer
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(last_q) && $stable(div_q)));

endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb_top;

  localparam int DW = 64;
  localparam int IW = 6;
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [IW-1:0] char_len = '0;
  logic [VW-1:0] divider = '0;
  logic          launch_rise = 1'b0;
  logic          sample_fall = 1'b0;
  logic          lsb_first = 1'b0;
  logic          load = 1'b0;
  logic [DW-1:0] load_data = '0;
  logic          miso = 1'b0;
  logic          sclk, mosi, busy, done;
  logic [DW-1:0] data_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int miso_mode = 2;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  spi_shift_engine dut_i (
    .clk(clk), .rst(rst), .start(start), .char_len(char_len), .divider(divider),
    .launch_rise(launch_rise), .sample_fall(sample_fall), .lsb_first(lsb_first),
    .load(load), .load_data(load_data), .miso(miso), .sclk(sclk), .mosi(mosi),
    .busy(busy), .done(done), .data_out(data_out)
  );

  // serial input stimulus
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (miso_mode)
      0: miso <= 1'b0;
      1: miso <= 1'b1;
      default: miso <= lfsr[0];
    endcase
  end

  // behavioural reference model
  logic          e_sclk, e_mosi, e_busy, e_done;
  logic [DW-1:0] e_data;
  logic          tx [DW];
  logic          m_lr, m_sf, m_lsb;
  int            m_len, m_half, m_cyc;

  always @(posedge clk) begin
    if (rst) begin
      e_sclk = 0; e_mosi = 0; e_busy = 0; e_done = 0; e_data = '0;
    end else begin
      e_done = 0;
      if (!e_busy) begin
        if (load) begin
          e_data = load_data;
        end else if (start) begin
          e_busy = 1;
          m_len  = (char_len == 0) ? DW : int'(char_len);
          m_half = int'(divider) + 1;
          m_lr = launch_rise; m_sf = sample_fall; m_lsb = lsb_first;
          m_cyc = 0;
          for (int k = 0; k < m_len; k++) tx[k] = m_lsb ? e_data[k] : e_data[m_len-1-k];
          if (!m_lr) e_mosi = tx[0];
        end
      end else begin
        m_cyc++;
        if (m_cyc % m_half == 0) begin
          int j;
          logic rising;
          j = m_cyc / m_half;
          rising = (j % 2) == 1;
          e_sclk = rising;
          if (rising != m_sf) begin
            if (m_lsb) begin
              for (int i = 0; i < m_len-1; i++) e_data[i] = e_data[i+1];
              e_data[m_len-1] = miso;
            end else begin
              for (int i = m_len-1; i > 0; i--) e_data[i] = e_data[i-1];
              e_data[0] = miso;
            end
          end
          if (m_lr && rising) e_mosi = tx[(j-1)/2];
          if (!m_lr && !rising && j < 2*m_len) e_mosi = tx[j/2];
          if (j == 2*m_len) begin
            e_busy = 0; e_done = 1; e_sclk = 0;
          end
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2", "sclk", DW'(sclk), DW'(e_sclk));
      chk("R4,R6", "mosi", DW'(mosi), DW'(e_mosi));
      chk("R8", "busy", DW'(busy), DW'(e_busy));
      chk("R8", "done", DW'(done), DW'(e_done));
      chk("R5,R7", "data_out", data_out, e_data);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic do_load(input logic [DW-1:0] v);
    @(negedge clk);
    load = 1; load_data = v;
    @(negedge clk);
    load = 0;
  endtask

  task automatic do_xfer(input int len, input int dv, input logic lr, input logic sf, input logic lsb);
    @(negedge clk);
    char_len = IW'(len); divider = VW'(dv);
    launch_rise = lr; sample_fall = sf; lsb_first = lsb;
    start = 1;
    @(negedge clk);
    start = 0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset outputs", {59'd0, sclk, mosi, busy, done, 1'b0}, '0);
    chk("R1", "reset data", data_out, '0);

    // R10: load while idle
    do_load(64'hDEAD_BEEF_0000_00A5);
    chk("R10", "loaded data", data_out, 64'hDEAD_BEEF_0000_00A5);

    // R7: all-ones input, 8 bits, upper bits kept
    miso_mode = 1;
    do_xfer(8, 1, 0, 0, 0);
    @(negedge clk);
    chk("R7", "8-bit rx with upper kept", data_out, 64'hDEAD_BEEF_0000_00FF);

    // R3: length 0 means 64 bits, zero input clears all
    do_load('1);
    miso_mode = 0;
    do_xfer(0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R3", "64-bit rx all zero", data_out, '0);

    // mode sweep with random input, R4 R5 R6
    miso_mode = 2;
    for (int m = 0; m < 8; m++) begin
      do_load(64'h0123_4567_89AB_CDEF ^ {8{8'(m * 37)}});
      do_xfer(5 + m * 7, m % 3, m[0], m[1], m[2]);
      // R7: resend received data without reload
      do_xfer(5 + m * 7, 2, m[1], m[0], m[2]);
    end

    // R9: pokes during a transfer are ignored
    do_load(64'h5555_AAAA_5555_AAAA);
    @(negedge clk);
    char_len = 6'd12; divider = 16'd2; launch_rise = 0; sample_fall = 1; lsb_first = 1;
    start = 1;
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);
    char_len = 6'd3; divider = 16'd0; launch_rise = 1; sample_fall = 0; lsb_first = 0;
    load = 1; load_data = '1; start = 1;
    @(negedge clk);
    load = 0; start = 0;
    while (!done) @(negedge clk);
    chk("R9", "pokes ignored, upper bits", data_out[63:12], 52'h5555_AAAA_5555_A);

    // R10: start with load in same cycle is ignored
    @(negedge clk);
    load = 1; load_data = 64'h1234; start = 1;
    @(negedge clk);
    load = 0; start = 0;
    @(negedge clk);
    chk("R10", "start with load ignored", DW'(busy), '0);
    chk("R10", "load with start", data_out, 64'h1234);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule